// File: doc/BRIEF.md
# Half-Bridge Gate Control Selector

This block produces the high-side and low-side gate enables for six half-bridge outputs. Each bridge has its own 3-bit mode field. The mode field picks one of four sources for the bridge: off, a direct 2-bit register command, the first PWM pin, or the second PWM pin. Each PWM source can drive the bridge in complementary fashion, on the low side only, or on the high side only.

Every bridge has a digital dead-time guard after its mode decoder. When a bridge moves its drive from one side to the other, the guard holds both gates off for a programmable number of clock cycles. The opposite side turns on only after that gap has passed. Both gate outputs are registered and reset to off.

The second PWM pin also serves as a current-sense output. The block raises a flag whenever any bridge claims that pin as an input, so the surrounding logic can release the sense function. Mode fields for bridges 5 and 6 come in on one configuration word. Mode fields for bridges 1 to 4 come in on a second configuration word.

Top module: `hb_gate_selector`

## Requirements
- R1: While `rst_n` is low, every `hs_en` and `ls_en` bit is 0.
- R2: Mode 3'b000 drives both gates of that bridge off, whatever its command and the PWM pins.
- R3: Mode 3'b001 follows the bridge's 2-bit command: 2'b00 means both gates off, 2'b01 means high side on, 2'b10 means low side on.
- R4: In mode 3'b001, command 2'b11 is reserved and drives both gates off.
- R5: Mode 3'b010 is complementary from `pwm1`: the low side follows `pwm1` and the high side follows its inverse.
- R6: Mode 3'b011 drives only the low side from `pwm1` and keeps the high side off. Mode 3'b100 drives only the high side from `pwm1` and keeps the low side off.
- R7: Modes 3'b101, 3'b110 and 3'b111 are the complementary, low-only and high-only forms of R5 and R6, taken from `pwm2`.
- R8: `sense_unavail` is 1 exactly when at least one bridge's mode is 3'b101, 3'b110 or 3'b111. It follows the mode inputs without a clock.
- R9: A change of mode, command or PWM level shows at the gates on the next rising clock edge, with no wait for a PWM edge or period. Static PWM levels hold the gates on for as long as they persist.
- R10: A side may turn on only after both gates have been off for at least `dead_cycles` consecutive cycles, counted since the opposite side was last on. Turning on the same side again, or turning on the first side after reset, does not wait.
- R11: For each bridge, `hs_en` and `ls_en` are never 1 together.
- R12: Bridge n (n = 1 to 4) takes its mode from `cfg_lo[3n-1:3n-3]`. Bridge 5 takes it from `cfg_hi[2:0]` and bridge 6 from `cfg_hi[5:3]`. Bridge n takes its command from `cmd[2n-1:2n-2]` and drives bit n-1 of `hs_en` and `ls_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo | input | 12 | Mode fields for bridges 1 to 4 |
| cfg_hi | input | 6 | Mode fields for bridges 5 and 6 |
| cmd | input | 12 | 2-bit register commands, one per bridge |
| pwm1 | input | 1 | First PWM input |
| pwm2 | input | 1 | Second PWM input, shared with the sense output |
| dead_cycles | input | 4 | Required off-gap, in clock cycles, before a side change |
| hs_en | output | 6 | High-side gate enables, registered |
| ls_en | output | 6 | Low-side gate enables, registered |
| sense_unavail | output | 1 | Second PWM pin is claimed as an input |

## Verification
The bench drives the six bridges with a different mode or command on each one in the same cycle. This catches any mix-up of field positions or bridge order. The PWM pins toggle every cycle to separate the complementary, low-only and high-only variants. Static high and low levels confirm that 100% duty is held. Driving `pwm1` and `pwm2` in opposite phase shows which pin a bridge really follows. The dead-time tests use slow PWM and register-driven side swaps, both direct and through an off cycle, to tell the required gap apart from an early or a late turn-on.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

   typedef enum logic [2:0] {
      HBM_OFF    = 3'b000,
      HBM_REG    = 3'b001,
      HBM_P1_CMP = 3'b010,
      HBM_P1_LO  = 3'b011,
      HBM_P1_HI  = 3'b100,
      HBM_P2_CMP = 3'b101,
      HBM_P2_LO  = 3'b110,
      HBM_P2_HI  = 3'b111
   } hb_mode_e;

   typedef enum logic [1:0] {
      CMD_NONE = 2'b00,
      CMD_HIGH = 2'b01,
      CMD_LOW  = 2'b10,
      CMD_RSVD = 2'b11
   } hb_cmd_e;

   typedef enum logic [1:0] {
      SIDE_NONE = 2'b00,
      SIDE_HIGH = 2'b01,
      SIDE_LOW  = 2'b10
   } hb_side_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } hb_gate_t;

   localparam int unsigned MODE_W = 3;
   localparam int unsigned CMD_W  = 2;

   // Modes 101, 110 and 111 take the second PWM pin.
   function automatic logic mode_uses_pwm2(input logic [MODE_W-1:0] m);
      return m[2] & (m[1] | m[0]);
   endfunction

endpackage

// File: rtl/hb_mode_decode.sv
module hb_mode_decode
   import hb_gate_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   input  logic [CMD_W-1:0]  cmd,
   input  logic              pwm_a,
   input  logic              pwm_b,
   output hb_gate_t          req
);

   always_comb begin
      req = '0;
      case (hb_mode_e'(mode))
         HBM_REG: begin
            case (hb_cmd_e'(cmd))
               CMD_HIGH: req.hi = 1'b1;
               CMD_LOW:  req.lo = 1'b1;
               default:  req    = '0;  // CMD_NONE and the reserved code
            endcase
         end
         HBM_P1_CMP: begin
            req.hi = ~pwm_a;
            req.lo = pwm_a;
         end
         HBM_P1_LO:  req.lo = pwm_a;
         HBM_P1_HI:  req.hi = pwm_a;
         HBM_P2_CMP: begin
            req.hi = ~pwm_b;
            req.lo = pwm_b;
         end
         HBM_P2_LO:  req.lo = pwm_b;
         HBM_P2_HI:  req.hi = pwm_b;
         default:    req    = '0;
      endcase
   end

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
   import hb_gate_pkg::*;
#(
   parameter int unsigned DT_W = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DT_W-1:0] dead_cycles,
   input  hb_gate_t        req,
   output logic            hs_q,
   output logic            ls_q
);

   localparam logic [DT_W-1:0] GAP_MAX = {DT_W{1'b1}};

   hb_side_e        last_q, last_d;
   logic [DT_W-1:0] gap_q, gap_d;
   logic            gap_ok;
   logic            hs_d, ls_d;

   // The gap counts consecutive cycles with both gates off, saturating.
   assign gap_ok = (gap_q >= dead_cycles);

   always_comb begin
      hs_d = req.hi && ((last_q != SIDE_LOW)  || gap_ok);
      ls_d = req.lo && ((last_q != SIDE_HIGH) || gap_ok);
      if (hs_d || ls_d)
         gap_d = '0;
      else if (gap_q == GAP_MAX)
         gap_d = gap_q;
      else
         gap_d = gap_q + 1'b1;
      if (hs_d)
         last_d = SIDE_HIGH;
      else if (ls_d)
         last_d = SIDE_LOW;
      else
         last_d = last_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q   <= 1'b0;
         ls_q   <= 1'b0;
         gap_q  <= '0;
         last_q <= SIDE_NONE;
      end else begin
         hs_q   <= hs_d;
         ls_q   <= ls_d;
         gap_q  <= gap_d;
         last_q <= last_d;
      end
   end

   a_r11_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_q && ls_q));

   a_r10_gap_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_q && dead_cycles != '0) |=> !hs_q);

   a_r10_gap_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_q && dead_cycles != '0) |=> !ls_q);

   a_r9_same_side_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (req.hi && last_q != SIDE_LOW) |=> hs_q);

endmodule

// File: rtl/hb_gate_selector.sv
module hb_gate_selector
   import hb_gate_pkg::*;
#(
   parameter int unsigned N_BR      = 6,
   parameter int unsigned LO_CNT    = 4,
   parameter int unsigned DT_W      = 4,
   parameter bit          SENSE_REG = 1'b0
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [MODE_W*LO_CNT-1:0]    cfg_lo,
   input  logic [MODE_W*(N_BR-LO_CNT)-1:0] cfg_hi,
   input  logic [CMD_W*N_BR-1:0]       cmd,
   input  logic                        pwm1,
   input  logic                        pwm2,
   input  logic [DT_W-1:0]             dead_cycles,
   output logic [N_BR-1:0]             hs_en,
   output logic [N_BR-1:0]             ls_en,
   output logic                        sense_unavail
);

   localparam int unsigned HI_CNT = N_BR - LO_CNT;

   if (LO_CNT < 1 || LO_CNT >= N_BR) begin : g_bad_split
      $error("hb_gate_selector: LO_CNT must lie in 1..N_BR-1");
   end
   if (DT_W < 1 || DT_W > 16) begin : g_bad_dtw
      $error("hb_gate_selector: DT_W must lie in 1..16");
   end

   logic [N_BR-1:0][MODE_W-1:0] mode_w;
   logic [N_BR-1:0]             p2_claim;
   hb_gate_t                    req_w [N_BR];

   for (genvar b = 0; b < N_BR; b++) begin : g_br
      if (b < LO_CNT) begin : g_lo
         assign mode_w[b] = cfg_lo[MODE_W*b +: MODE_W];
      end else begin : g_hi
         assign mode_w[b] = cfg_hi[MODE_W*(b-LO_CNT) +: MODE_W];
      end

      assign p2_claim[b] = mode_uses_pwm2(mode_w[b]);

      hb_mode_decode u_dec (
         .mode  (mode_w[b]),
         .cmd   (cmd[CMD_W*b +: CMD_W]),
         .pwm_a (pwm1),
         .pwm_b (pwm2),
         .req   (req_w[b])
      );

      hb_deadtime #(.DT_W(DT_W)) u_dt (
         .clk         (clk),
         .rst_n       (rst_n),
         .dead_cycles (dead_cycles),
         .req         (req_w[b]),
         .hs_q        (hs_en[b]),
         .ls_q        (ls_en[b])
      );

      a_r2_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_w[b] == HBM_OFF) |=> (!hs_en[b] && !ls_en[b]));

      a_r4_reserved_cmd: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_w[b] == HBM_REG && cmd[CMD_W*b +: CMD_W] == CMD_RSVD)
            |=> (!hs_en[b] && !ls_en[b]));

      a_r6_low_only_p1: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_w[b] == HBM_P1_LO) |=> !hs_en[b]);
   end

   if (SENSE_REG) begin : g_sense_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sense_unavail <= 1'b0;
         else        sense_unavail <= |p2_claim;
      end
   end else begin : g_sense_comb
      assign sense_unavail = |p2_claim;
   end

endmodule

// File: tb/hb_gate_selector_tb.sv
`timescale 1ns/1ps
module hb_gate_selector_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] cfg_lo;
   logic [5:0]  cfg_hi;
   logic [11:0] cmd;
   logic        pwm1, pwm2;
   logic [3:0]  dead_cycles;
   logic [5:0]  hs_en, ls_en;
   logic        sense_unavail;

   always #2.5 clk = ~clk;

   hb_gate_selector u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cmd(cmd),
      .pwm1(pwm1), .pwm2(pwm2), .dead_cycles(dead_cycles),
      .hs_en(hs_en), .ls_en(ls_en), .sense_unavail(sense_unavail)
   );

   typedef struct {
      logic [5:0] hs;
      logic [5:0] ls;
      logic       sn;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 0;

   int         m_last [6];  // 0 none, 1 high, 2 low
   int         m_gap  [6];

   // Gate request per the mode table: {hi, lo}
   function automatic logic [1:0] ref_req(input logic [2:0] m, input logic [1:0] c,
                                          input logic a, input logic b);
      case (m)
         3'b001: return (c == 2'b01) ? 2'b10 : (c == 2'b10) ? 2'b01 : 2'b00;
         3'b010: return {~a, a};
         3'b011: return {1'b0, a};
         3'b100: return {a, 1'b0};
         3'b101: return {~b, b};
         3'b110: return {1'b0, b};
         3'b111: return {b, 1'b0};
         default: return 2'b00;
      endcase
   endfunction

   // Drive one cycle of inputs (at a falling edge) and queue the expectation
   task automatic drive(input logic [17:0] modes, input logic [11:0] c,
                        input logic p1, input logic p2, input logic [3:0] dt,
                        input string tag);
      exp_t e;
      cfg_lo = modes[11:0];
      cfg_hi = modes[17:12];
      cmd = c; pwm1 = p1; pwm2 = p2; dead_cycles = dt;
      e.sn = 1'b0;
      for (int b = 0; b < 6; b++) begin
         logic [2:0] m;
         logic [1:0] r;
         logic h, l;
         m = modes[3*b +: 3];
         r = ref_req(m, c[2*b +: 2], p1, p2);
         h = r[1] && (m_last[b] != 2 || m_gap[b] >= int'(dt));
         l = r[0] && (m_last[b] != 1 || m_gap[b] >= int'(dt));
         if (h || l) m_gap[b] = 0;
         else if (m_gap[b] < 15) m_gap[b]++;
         if (h) m_last[b] = 1;
         else if (l) m_last[b] = 2;
         e.hs[b] = h;
         e.ls[b] = l;
         if (m[2] && (m[1] || m[0])) e.sn = 1'b1;
      end
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: compares one queued item just after each rising edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (hs_en !== e.hs || ls_en !== e.ls || sense_unavail !== e.sn) begin
            n_bad++;
            $display("FAIL %s: hs=%b ls=%b sense=%b expected hs=%b ls=%b sense=%b",
                     e.tag, hs_en, ls_en, sense_unavail, e.hs, e.ls, e.sn);
         end
         n_chk++;
         if ((hs_en & ls_en) !== 6'b0) begin
            n_bad++;
            $display("FAIL R11 overlap: hs=%b ls=%b expected overlap=000000",
                     hs_en, ls_en);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      for (int b = 0; b < 6; b++) begin
         m_last[b] = 0;
         m_gap[b]  = 0;
      end
      rst_n = 1'b0;
      cfg_lo = '0; cfg_hi = '0; cmd = 12'hFFF; pwm1 = 1'b1; pwm2 = 1'b1;
      dead_cycles = 4'd0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (hs_en !== 6'b0 || ls_en !== 6'b0) begin
         n_bad++;
         $display("FAIL R1 reset: hs=%b ls=%b expected 000000/000000", hs_en, ls_en);
      end
      n_chk++;
      if (sense_unavail !== 1'b0) begin
         n_bad++;
         $display("FAIL R8 reset sense=%b expected 0", sense_unavail);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2: all off regardless of command and pins
      for (int k = 0; k < 3; k++)
         drive(18'o000000, 12'hFFF, k[0], ~k[0], 4'd0, "R2 off mode");

      // R3 R4 R12: register mode, a different command per bridge
      drive(18'o111111, 12'b10_01_00_11_10_01, 1'b0, 1'b0, 4'd0, "R3 R4 R12 reg cmds");
      drive(18'o111111, 12'b01_10_11_00_01_10, 1'b0, 1'b0, 4'd0, "R3 R4 R12 reg swap");
      drive(18'o111111, 12'b11_00_10_01_11_00, 1'b1, 1'b1, 4'd0, "R3 R4 R12 reg rot");
      drive(18'o111111, 12'hFFF, 1'b1, 1'b1, 4'd0, "R4 reserved all");

      // R5 R6: PWM1 modes, toggling every cycle, pwm2 opposite
      for (int k = 0; k < 8; k++)
         drive(18'o432432, 12'h000, k[0], ~k[0], 4'd0, "R5 R6 pwm1 toggle");
      // R9: static levels hold
      for (int k = 0; k < 5; k++)
         drive(18'o432432, 12'h000, 1'b1, 1'b0, 4'd0, "R9 static high");
      for (int k = 0; k < 5; k++)
         drive(18'o432432, 12'h000, 1'b0, 1'b1, 4'd0, "R9 static low");

      // R7 R8: PWM2 modes with pwm1 opposite
      for (int k = 0; k < 8; k++)
         drive(18'o765765, 12'h000, ~k[0], k[0], 4'd0, "R7 R8 pwm2 toggle");
      drive(18'o000005, 12'h000, 1'b0, 1'b1, 4'd0, "R8 one bridge claims pwm2");
      drive(18'o500000, 12'h000, 1'b0, 1'b1, 4'd0, "R8 R12 bridge6 claims pwm2");
      drive(18'o044444, 12'h000, 1'b1, 1'b0, 4'd0, "R8 no claim");

      // R9: mode change takes effect at the next edge
      drive(18'o111111, 12'h555, 1'b0, 1'b0, 4'd0, "R9 reg high");
      drive(18'o444444, 12'h555, 1'b0, 1'b0, 4'd0, "R9 switch to pwm1 high");
      drive(18'o000000, 12'h555, 1'b1, 1'b1, 4'd0, "R9 switch to off");

      // R10: complementary PWM1 with dead time 3, slow periods
      for (int r = 0; r < 2; r++) begin
         for (int k = 0; k < 8; k++)
            drive(18'o222222, 12'h000, 1'b1, 1'b0, 4'd3, "R10 dead time low phase");
         for (int k = 0; k < 8; k++)
            drive(18'o222222, 12'h000, 1'b0, 1'b0, 4'd3, "R10 dead time high phase");
      end

      // R10: register swap via one off cycle, dead time 2
      for (int k = 0; k < 3; k++)
         drive(18'o111111, 12'h555, 1'b0, 1'b0, 4'd2, "R10 reg high");
      drive(18'o111111, 12'h000, 1'b0, 1'b0, 4'd2, "R10 reg off gap");
      for (int k = 0; k < 4; k++)
         drive(18'o111111, 12'hAAA, 1'b0, 1'b0, 4'd2, "R10 reg low after gap");
      drive(18'o111111, 12'h000, 1'b0, 1'b0, 4'd2, "R10 reg off");
      for (int k = 0; k < 2; k++)
         drive(18'o111111, 12'hAAA, 1'b0, 1'b0, 4'd2, "R10 same side no wait");
      // R10: maximum dead time, direct swap
      for (int k = 0; k < 18; k++)
         drive(18'o111111, 12'h555, 1'b0, 1'b0, 4'd15, "R10 max dead time");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule